// File: doc/BRIEF.md
# Pin-Serial Program Memory Loader

This block is the device-side sequencer that lets an external programmer write and read back a 10-bit-wide program store through a narrow pin set that has no address pins. A four-bit mode code picks the operation, a pulse input steps an internal address counter, and an 8-bit data bus carries each 10-bit word in two halves. The block drives a behavioural memory array through an address, a one-cycle write strobe and a write word, and takes the array's combinational read word back. It also controls the direction of the data bus.

All pins are sampled on the system clock. The pulse input passes through a two-stage synchronizer, and its falling edges are counted modulo four. The address moves up by one on the third falling edge of each group of four. The position inside the group selects the half of the word that the bus carries: the low half after a clear and after the third fall, the high half after the first and second falls. Mode codes below are written {MD3,MD2,MD1,MD0}.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset the address is 0, the bus is not driven (bus_oe_o = 0) and no write strobe is issued.
- R2: Mode code 4'b0101 sets the address to 0 and returns the pulse position to the start of a group, so the next read is the low half.
- R3: Each group of four falling edges on pclk_i advances the address by exactly one. The step happens on the third falling edge. The first, second and fourth falls leave the address unchanged.
- R4: The low half of the word is selected after a clear and after the third and fourth falls. The high half is selected after the first and second falls.
- R5: Mode code 4'b1100 (verify) drives the bus. In the low half it drives word[7:0], and in the high half it drives {6'b0, word[9:8]} of the current address.
- R6: In every mode other than verify, bus_oe_o is 0 and bus_o is 0.
- R7: Entering mode code 4'b1110 (write) issues exactly one one-cycle write strobe, however long the mode is held.
- R8: A write in the low half replaces bits 7:0 with bus_i and keeps bits 9:8. A write in the high half replaces bits 9:8 with bus_i[1:0] and keeps bits 7:0.
- R9: Codes 11x1 (inhibit) and every unlisted code neither write, nor drive the bus, nor change the address. Pulses keep counting in these codes.
- R10: The address stops at 7E9h and never enters the reserved range 7EAh to 7FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Mode code, bit 0 is MD0 |
| pclk_i | input | 1 | Address step pulse, asynchronous |
| bus_i | input | 8 | Data bus input side |
| bus_o | output | 8 | Data bus output side |
| bus_oe_o | output | 1 | Data bus output enable |
| mem_addr_o | output | 11 | Array address |
| mem_we_o | output | 1 | Array write strobe |
| mem_wdata_o | output | 10 | Array write word |
| mem_rdata_i | input | 10 | Array read word |

## Verification
The hardest case to reach from the pins is the saturation at the last valid address. Getting there takes more than eight thousand pulses, each of which must survive the synchronizer. The bench steps the counter there with pulses that are only just long enough, then checks that further pulses leave the address at 7E9h. The merge of a half-word write needs the right pulse position when write mode is entered. The bench reaches it with a clear followed by a counted number of pulses, and reads the result back through verify mode.

// File: rtl/otp_prog_seq.sv
module otp_prog_seq #(
  parameter int AW = 11,
  parameter int DW = 10,
  parameter int BW = 8,
  parameter logic [AW-1:0] LAST_ADDR = 11'h7E9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode_i,
  input  logic          pclk_i,
  input  logic [BW-1:0] bus_i,
  output logic [BW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int HW = DW - BW;

  typedef enum logic [1:0] {M_INH, M_CLR, M_WR, M_VER} mode_e;

  mode_e mode_d, mode_q;
  logic [2:0] pc_sh;
  logic [1:0] cnt;
  logic [AW-1:0] addr;
  logic fall, phase_hi, we_q;
  logic [DW-1:0] wdata_q;

  always_comb begin
    case (mode_i)
      4'b0101: mode_d = M_CLR;
      4'b1110: mode_d = M_WR;
      4'b1100: mode_d = M_VER;
      default: mode_d = M_INH;
    endcase
  end

  assign fall     = pc_sh[2] & ~pc_sh[1];
  assign phase_hi = cnt[0] ^ cnt[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_INH;
      pc_sh   <= '0;
      cnt     <= '0;
      addr    <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      mode_q <= mode_d;
      pc_sh  <= {pc_sh[1:0], pclk_i};
      if (mode_q == M_CLR) begin
        cnt  <= '0;
        addr <= '0;
      end else if (fall) begin
        cnt <= cnt + 2'd1;
        if (cnt == 2'd2 && addr != LAST_ADDR) addr <= addr + 1'b1;
      end
      we_q <= (mode_d == M_WR) && (mode_q != M_WR);
      wdata_q <= phase_hi ? {bus_i[HW-1:0], mem_rdata_i[BW-1:0]}
                          : {mem_rdata_i[DW-1:BW], bus_i};
    end
  end

  assign mem_addr_o  = addr;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wdata_q;
  assign bus_oe_o    = (mode_q == M_VER);
  assign bus_o = !bus_oe_o ? '0 :
                 phase_hi  ? {{(BW-HW){1'b0}}, mem_rdata_i[DW-1:BW]} :
                             mem_rdata_i[BW-1:0];
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
  parameter int AW = 11,
  parameter logic [AW-1:0] LAST_ADDR = 11'h7E9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic          bus_oe_o
);
  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'b0101) |-> ##2 (mem_addr_o == '0));

  a_r3_addr_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr_o != $past(mem_addr_o)) |->
      (mem_addr_o == AW'($past(mem_addr_o) + 1'b1) || mem_addr_o == '0));

  a_r6_drive_only_verify: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> ($past(mode_i) == 4'b1100));

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);

  a_r7_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ($past(mode_i) == 4'b1110));

  a_r10_addr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr_o <= LAST_ADDR);
endmodule

bind otp_prog_seq otp_prog_seq_chk #(.AW(AW), .LAST_ADDR(LAST_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mem_addr_o(mem_addr_o),
  .mem_we_o(mem_we_o), .bus_oe_o(bus_oe_o)
);

// File: tb/otp_prog_seq_tb_top.sv
module otp_prog_seq_tb_top;
  localparam logic [3:0] C_CLR = 4'b0101, C_WR = 4'b1110, C_VER = 4'b1100, C_INH = 4'b1101;

  logic clk = 1'b0, rst_n = 1'b0, pclk = 1'b0;
  logic [3:0] mode = C_INH;
  logic [7:0] bus_i = '0, bus_o;
  logic bus_oe, mem_we;
  logic [10:0] mem_addr;
  logic [9:0] mem_wdata, mem_rdata;
  logic [9:0] mem [0:2047];
  int total = 0, bad = 0, we_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  otp_prog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .pclk_i(pclk), .bus_i(bus_i),
    .bus_o(bus_o), .bus_oe_o(bus_oe), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  function automatic logic [9:0] init_word(int i);
    return 10'((i * 211 + 'h2C7) & 'h3FF);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk) mode = m;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk) pclk = 1'b1;
    repeat (3) @(negedge clk);
    pclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic go_addr(input int n);
    set_mode(C_CLR);
    set_mode(C_INH);
    for (int i = 0; i < 4 * n; i++) pulse();
  endtask

  task automatic t_reset();
    check(mem_addr == 0, "R1 addr", 32'(mem_addr), 0);
    check(bus_oe == 0, "R1 oe", 32'(bus_oe), 0);
    check(we_cnt == 0, "R1 strobe", we_cnt, 0);
  endtask

  task automatic t_step();
    go_addr(0);
    pulse(); check(mem_addr == 0, "R3 first fall", 32'(mem_addr), 0);
    pulse(); check(mem_addr == 0, "R3 second fall", 32'(mem_addr), 0);
    pulse(); check(mem_addr == 1, "R3 third fall", 32'(mem_addr), 1);
    pulse(); check(mem_addr == 1, "R3 fourth fall", 32'(mem_addr), 1);
    for (int i = 0; i < 8; i++) pulse();
    check(mem_addr == 3, "R3 two groups", 32'(mem_addr), 3);
    set_mode(C_CLR);
    check(mem_addr == 0, "R2 clear", 32'(mem_addr), 0);
    set_mode(C_INH);
  endtask

  task automatic t_write();
    logic [9:0] w0, exp;
    int c0;
    w0 = init_word(2);
    go_addr(2);
    bus_i = 8'h3C;
    c0 = we_cnt;
    set_mode(C_WR);
    repeat (10) @(negedge clk);
    set_mode(C_INH);
    check(we_cnt - c0 == 1, "R7 one strobe", we_cnt - c0, 1);
    exp = {w0[9:8], 8'h3C};
    check(mem[2] == exp, "R8 low half write", 32'(mem[2]), 32'(exp));
    pulse();
    bus_i = 8'hFE;
    set_mode(C_WR);
    set_mode(C_INH);
    exp = {2'b10, 8'h3C};
    check(mem[2] == exp, "R8 high half write", 32'(mem[2]), 32'(exp));
    check(we_cnt - c0 == 2, "R7 second entry", we_cnt - c0, 2);
  endtask

  task automatic t_inhibit();
    logic [3:0] codes [4] = '{4'b1111, 4'b1101, 4'b0000, 4'b1010};
    logic [9:0] keep;
    int c0;
    keep = mem[2];
    c0 = we_cnt;
    bus_i = 8'h55;
    foreach (codes[k]) begin
      set_mode(codes[k]);
      check(bus_oe == 0 && bus_o == 0, "R9 no drive", {bus_oe, bus_o}, 0);
      check(mem_addr == 2, "R9 addr kept", 32'(mem_addr), 2);
      check(bus_oe == 0, "R6 oe off", 32'(bus_oe), 0);
    end
    check(we_cnt == c0, "R9 no strobe", we_cnt, c0);
    check(mem[2] == keep, "R9 word kept", 32'(mem[2]), 32'(keep));
  endtask

  task automatic t_verify();
    logic [9:0] w0, w1;
    w0 = init_word(0);
    w1 = init_word(1);
    set_mode(C_CLR);
    set_mode(C_VER);
    check(bus_oe == 1, "R5 oe on", 32'(bus_oe), 1);
    check(bus_o == w0[7:0], "R2 R5 low half after clear", 32'(bus_o), 32'(w0[7:0]));
    pulse();
    check(bus_o == {6'b0, w0[9:8]}, "R4 R5 high half", 32'(bus_o), 32'({6'b0, w0[9:8]}));
    pulse();
    check(bus_o == {6'b0, w0[9:8]}, "R4 still high", 32'(bus_o), 32'({6'b0, w0[9:8]}));
    pulse();
    check(mem_addr == 1 && bus_o == w1[7:0], "R4 next word low", 32'(bus_o), 32'(w1[7:0]));
    pulse();
    check(bus_o == w1[7:0], "R4 fourth fall low", 32'(bus_o), 32'(w1[7:0]));
    set_mode(C_INH);
    check(bus_oe == 0 && bus_o == 0, "R6 released", {bus_oe, bus_o}, 0);
  endtask

  task automatic t_sat();
    go_addr(11'h7E9);
    check(mem_addr == 11'h7E9, "R10 last addr", 32'(mem_addr), 32'h7E9);
    for (int i = 0; i < 8; i++) pulse();
    check(mem_addr == 11'h7E9, "R10 held", 32'(mem_addr), 32'h7E9);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_step();
    t_write();
    t_inhibit();
    t_verify();
    t_sat();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule